// File: doc/BRIEF.md
# Operand Address Byte Decoder

This block accepts the operand-addressing portion of an instruction one byte per clock, beginning with the addressing-mode byte. It reads the two-bit mode field (bits 7:6) and the three-bit register/memory field (bits 2:0). It then collects zero, one or two displacement bytes and reports where the operand lives. A memory operand yields a 16-bit effective address, formed from the supplied base and index register values, and a segment register selection. A register operand yields a register number and a width flag.

The byte input is a valid/ready stream. A byte moves when `in_valid` and `in_ready` are both high at a rising clock edge. The source may insert bubbles at any time by holding `in_valid` low. The decoder applies back-pressure for exactly one cycle per operand by holding `in_ready` low while `done` is high. A byte offered in that cycle stays with the source and is taken in a later cycle.

A segment override is posted on separate plain pins before or during an operand. Control inputs `wide_in` and `str_dst` are sampled together with the addressing-mode byte. Register values are sampled in the cycle that the last byte is accepted.

Top module: `opaddr_decoder`

## Requirements
- R1: Mode 11 is register-direct. The operand ends on the mode byte, `reg_direct`=1, `reg_num` = bits 2:0, `reg_wide` = `wide_in`, `ea`=0, `seg`=0 and `byte_count`=1.
- R2: Mode 00 with r/m other than 110 takes no displacement and reports `byte_count`=1.
- R3: Mode 00 with r/m 110 is a direct address. The next two bytes, low byte then high byte, form `ea` with no register added, and `byte_count`=3.
- R4: Mode 01 takes one displacement byte, sign-extended to 16 bits (0x80 gives 0xFF80), and reports `byte_count`=2.
- R5: Mode 10 takes a low then a high displacement byte and reports `byte_count`=3.
- R6: The memory address is the displacement plus a sum chosen by r/m: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX.
- R7: The address sum wraps modulo 2^16.
- R8: The segment code is 00 ES, 01 CS, 10 SS, 11 DS. With no override, a BP-based address (r/m 010, 011, or 110 outside direct mode) reports SS, and every other memory address reports DS.
- R9: An `ovr_valid` pulse with `ovr_byte` of the form 001 ss 110 replaces the default segment with ss. Any byte of another form is ignored.
- R10: When `str_dst` is high, the segment is ES regardless of any override.
- R11: A pending override is cleared in the cycle that `done` is high, so the next operand uses its default segment.
- R12: `done` is high for exactly one cycle, the cycle after the last byte is accepted. `in_ready` is low in that cycle, and a byte offered then is not consumed.
- R13: A synchronous reset drops `done`, raises `in_ready`, clears a pending override and abandons a partial operand, so the next byte is treated as a mode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte stream valid |
| in_byte | input | 8 | Byte stream data |
| in_ready | output | 1 | Byte stream ready |
| wide_in | input | 1 | Width bit for a register operand |
| str_dst | input | 1 | Operand is a string destination |
| ovr_valid | input | 1 | Override byte strobe |
| ovr_byte | input | 8 | Candidate override prefix byte |
| reg_bx | input | AW | Base register BX value |
| reg_bp | input | AW | Base register BP value |
| reg_si | input | AW | Index register SI value |
| reg_di | input | AW | Index register DI value |
| done | output | 1 | Operand result strobe |
| ea | output | AW | Effective address |
| seg | output | 2 | Selected segment code |
| reg_direct | output | 1 | Operand is a register |
| reg_num | output | 3 | Register number |
| reg_wide | output | 1 | Register is 16 bits wide |
| byte_count | output | 2 | Bytes consumed by the operand |

## Verification
The bench builds the decoder with the default address width of 16. At that width, random register values and displacements regularly push the sum past 0xFFFF, so the wrap rule is exercised without special setup. A full 8-bit displacement range also reaches the sign-extension boundary at 0x7F and 0x80. Random bubbles on `in_valid`, together with a junk byte offered during every `done` cycle, bring the back-pressure rule within reach on every operand.

// File: rtl/oab_pkg.sv
package oab_pkg;
  typedef enum logic [1:0] {SEG_ES = 2'b00, SEG_CS = 2'b01, SEG_SS = 2'b10, SEG_DS = 2'b11} seg_e;
  typedef enum logic [1:0] {ST_MODE, ST_DLO, ST_DHI, ST_DONE} oab_st_e;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/oab_ovr.sv
module oab_ovr
  import oab_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ovr_valid,
  input  logic [BYTE_W-1:0] ovr_byte,
  input  logic             clear,
  output logic             pend,
  output seg_e             pend_seg
);
  logic match;
  assign match = (ovr_byte[7:5] == 3'b001) && (ovr_byte[2:0] == 3'b110);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend     <= 1'b0;
      pend_seg <= SEG_DS;
    end else if (ovr_valid && match) begin
      pend     <= 1'b1;
      pend_seg <= seg_e'(ovr_byte[4:3]);
    end
  end
endmodule

// File: rtl/oab_seq.sv
module oab_seq
  import oab_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              take_mode,
  output logic              last,
  output logic              in_done,
  output logic [1:0]        mode_c,
  output logic [2:0]        rm_c,
  output logic              direct_c,
  output logic [AW-1:0]     disp_c,
  output logic [1:0]        count_c
);
  oab_st_e           state_q, state_d;
  logic [1:0]        mode_q;
  logic [2:0]        rm_q;
  logic [BYTE_W-1:0] lo_q;
  logic [1:0]        cnt_q;
  logic              acc;

  assign in_ready  = (state_q != ST_DONE);
  assign in_done   = (state_q == ST_DONE);
  assign acc       = in_valid && in_ready;
  assign take_mode = acc && (state_q == ST_MODE);
  assign mode_c    = (state_q == ST_MODE) ? in_byte[7:6] : mode_q;
  assign rm_c      = (state_q == ST_MODE) ? in_byte[2:0] : rm_q;
  assign direct_c  = (mode_c == 2'b00) && (rm_c == 3'b110);
  assign count_c   = cnt_q + 2'd1;

  always_comb begin
    state_d = state_q;
    last    = 1'b0;
    disp_c  = '0;
    unique case (state_q)
      ST_MODE: if (acc) begin
        if (mode_c == 2'b11 || (mode_c == 2'b00 && !direct_c)) begin
          last    = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d = ST_DLO;
        end
      end
      ST_DLO: if (acc) begin
        if (mode_c == 2'b01) begin
          last    = 1'b1;
          disp_c  = AW'($signed(in_byte));
          state_d = ST_DONE;
        end else begin
          state_d = ST_DHI;
        end
      end
      ST_DHI: if (acc) begin
        last    = 1'b1;
        disp_c  = AW'({in_byte, lo_q});
        state_d = ST_DONE;
      end
      default: state_d = ST_MODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_MODE;
      cnt_q   <= '0;
      mode_q  <= '0;
      rm_q    <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DONE) cnt_q <= '0;
      else if (acc)           cnt_q <= cnt_q + 2'd1;
      if (take_mode) begin
        mode_q <= in_byte[7:6];
        rm_q   <= in_byte[2:0];
      end
      if (acc && state_q == ST_DLO) lo_q <= in_byte;
    end
  end
endmodule

// File: rtl/oab_ea.sv
module oab_ea #(
  parameter int AW = 16
) (
  input  logic [2:0]    rm,
  input  logic          regdir,
  input  logic          direct,
  input  logic [AW-1:0] bx,
  input  logic [AW-1:0] bp,
  input  logic [AW-1:0] si,
  input  logic [AW-1:0] di,
  input  logic [AW-1:0] disp,
  output logic [AW-1:0] ea,
  output logic          bp_based
);
  logic [AW-1:0] base;

  always_comb begin
    unique case (rm)
      3'b000:  base = bx + si;
      3'b001:  base = bx + di;
      3'b010:  base = bp + si;
      3'b011:  base = bp + di;
      3'b100:  base = si;
      3'b101:  base = di;
      3'b110:  base = bp;
      default: base = bx;
    endcase
    if (regdir)      ea = '0;
    else if (direct) ea = disp;
    else             ea = base + disp;
    bp_based = !regdir && !direct &&
               (rm == 3'b010 || rm == 3'b011 || rm == 3'b110);
  end
endmodule

// File: rtl/opaddr_decoder.sv
module opaddr_decoder
  import oab_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          in_ready,
  input  logic          wide_in,
  input  logic          str_dst,
  input  logic          ovr_valid,
  input  logic [7:0]    ovr_byte,
  input  logic [AW-1:0] reg_bx,
  input  logic [AW-1:0] reg_bp,
  input  logic [AW-1:0] reg_si,
  input  logic [AW-1:0] reg_di,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic [1:0]    seg,
  output logic          reg_direct,
  output logic [2:0]    reg_num,
  output logic          reg_wide,
  output logic [1:0]    byte_count
);
  logic          take_mode, last, in_done, direct_c, regdir_c, bp_based;
  logic [1:0]    mode_c, count_c;
  logic [2:0]    rm_c;
  logic [AW-1:0] disp_c, ea_c;
  logic          pend, wide_q, str_q, wide_c, str_c;
  seg_e          pend_seg, seg_c;

  oab_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .take_mode(take_mode), .last(last), .in_done(in_done),
    .mode_c(mode_c), .rm_c(rm_c), .direct_c(direct_c), .disp_c(disp_c),
    .count_c(count_c)
  );

  oab_ovr u_ovr (
    .clk(clk), .rst(rst), .ovr_valid(ovr_valid), .ovr_byte(ovr_byte),
    .clear(in_done), .pend(pend), .pend_seg(pend_seg)
  );

  assign regdir_c = (mode_c == 2'b11);

  oab_ea #(.AW(AW)) u_ea (
    .rm(rm_c), .regdir(regdir_c), .direct(direct_c),
    .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
    .disp(disp_c), .ea(ea_c), .bp_based(bp_based)
  );

  assign wide_c = take_mode ? wide_in : wide_q;
  assign str_c  = take_mode ? str_dst : str_q;

  always_comb begin
    if (regdir_c)      seg_c = SEG_ES;
    else if (str_c)    seg_c = SEG_ES;
    else if (pend)     seg_c = pend_seg;
    else if (bp_based) seg_c = SEG_SS;
    else               seg_c = SEG_DS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      ea         <= '0;
      seg        <= '0;
      reg_direct <= 1'b0;
      reg_num    <= '0;
      reg_wide   <= 1'b0;
      byte_count <= '0;
      wide_q     <= 1'b0;
      str_q      <= 1'b0;
    end else begin
      done <= last;
      if (take_mode) begin
        wide_q <= wide_in;
        str_q  <= str_dst;
      end
      if (last) begin
        ea         <= ea_c;
        seg        <= seg_c;
        reg_direct <= regdir_c;
        reg_num    <= regdir_c ? rm_c : 3'b000;
        reg_wide   <= regdir_c ? wide_c : 1'b0;
        byte_count <= count_c;
      end
    end
  end
endmodule

// File: rtl/oab_chk.sv
module oab_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          done,
  input logic          reg_direct,
  input logic [AW-1:0] ea,
  input logic [1:0]    byte_count
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R12
  stall_chk: assert property (@(posedge clk) disable iff (rst) done |-> !in_ready);
  // R1
  regdir_chk: assert property (@(posedge clk) disable iff (rst)
    (done && reg_direct) |-> (byte_count == 2'd1 && ea == '0));
  // R5
  count_chk: assert property (@(posedge clk) disable iff (rst) done |-> byte_count != 2'd0);
  // R13
  reset_chk: assert property (@(posedge clk) rst |=> (!done && in_ready));
endmodule

bind opaddr_decoder oab_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .done(done),
  .reg_direct(reg_direct), .ea(ea), .byte_count(byte_count)
);

// File: tb/test_opaddr_decoder.sv
`timescale 1ns/1ps
module test_opaddr_decoder;
  localparam int AW = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, wide_in = 1'b0, str_dst = 1'b0, ovr_valid = 1'b0;
  logic [7:0] in_byte = '0, ovr_byte = '0;
  logic [AW-1:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic in_ready, done, reg_direct, reg_wide;
  logic [AW-1:0] ea;
  logic [1:0] seg, byte_count;
  logic [2:0] reg_num;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  opaddr_decoder #(.AW(AW)) i_opaddr_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .wide_in(wide_in), .str_dst(str_dst), .ovr_valid(ovr_valid), .ovr_byte(ovr_byte),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .done(done), .ea(ea), .seg(seg), .reg_direct(reg_direct), .reg_num(reg_num),
    .reg_wide(reg_wide), .byte_count(byte_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_ea(input logic [1:0] md, input logic [2:0] rm,
                                         input logic [15:0] disp);
    logic [15:0] b;
    case (rm)
      3'd0: b = reg_bx + reg_si;
      3'd1: b = reg_bx + reg_di;
      3'd2: b = reg_bp + reg_si;
      3'd3: b = reg_bp + reg_di;
      3'd4: b = reg_si;
      3'd5: b = reg_di;
      3'd6: b = reg_bp;
      default: b = reg_bx;
    endcase
    if (md == 2'b11) return 16'h0;
    if (md == 2'b00 && rm == 3'd6) return disp;
    return b + disp;
  endfunction

  function automatic logic [1:0] ref_seg(input logic [1:0] md, input logic [2:0] rm,
                                         input bit strd, input bit ov, input logic [1:0] ss);
    if (md == 2'b11) return 2'b00;
    if (strd) return 2'b00;
    if (ov) return ss;
    if (!(md == 2'b00 && rm == 3'd6) && (rm == 3'd2 || rm == 3'd3 || rm == 3'd6)) return 2'b10;
    return 2'b11;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    bit got = 0;
    while (!got) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) in_valid = 1'b0;
      else begin
        in_valid = 1'b1;
        in_byte  = b;
        got      = in_ready;
      end
    end
  endtask

  task automatic post_ovr(input logic [7:0] b);
    @(negedge clk);
    ovr_valid = 1'b1;
    ovr_byte  = b;
    @(negedge clk);
    ovr_valid = 1'b0;
  endtask

  // one operand: optional override byte, mode byte, displacement bytes, then checks
  task automatic run_op(input logic [1:0] md, input logic [2:0] rm, input logic [7:0] d0,
                        input logic [7:0] d1, input bit w, input bit strd,
                        input bit use_ovr, input logic [7:0] ob, input bit rnd_regs);
    logic [15:0] disp, e_ea;
    logic [1:0] e_cnt, e_seg;
    bit ov;
    @(negedge clk);
    if (rnd_regs) begin
      reg_bx = 16'($urandom); reg_bp = 16'($urandom);
      reg_si = 16'($urandom); reg_di = 16'($urandom);
    end
    wide_in = w;
    str_dst = strd;
    ov = use_ovr && ob[7:5] == 3'b001 && ob[2:0] == 3'b110;
    if (use_ovr) post_ovr(ob);
    send_byte({md, 3'($urandom), rm});
    if (md == 2'b01) begin
      send_byte(d0); disp = 16'($signed(d0)); e_cnt = 2'd2;
    end else if (md == 2'b10 || (md == 2'b00 && rm == 3'd6)) begin
      send_byte(d0); send_byte(d1); disp = {d1, d0}; e_cnt = 2'd3;
    end else begin
      disp = 16'h0; e_cnt = 2'd1;
    end
    e_ea  = ref_ea(md, rm, disp);
    e_seg = ref_seg(md, rm, strd, ov, ob[4:3]);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'hC5; // junk mode-11 byte offered while stalled
    chk(done == 1'b1, "R12 done", int'(done), 1);
    chk(in_ready == 1'b0, "R12 stall", int'(in_ready), 0);
    chk(byte_count == e_cnt, (md == 2'b01) ? "R4 count" : (md == 2'b10) ? "R5 count" :
        (md == 2'b11) ? "R1 count" : "R2/R3 count", int'(byte_count), int'(e_cnt));
    chk(ea == e_ea, (md == 2'b00 && rm == 3'd6) ? "R3 ea" : "R6 ea", int'(ea), int'(e_ea));
    chk(seg == e_seg, strd ? "R10 seg" : ov ? "R9 seg" : "R8 seg", int'(seg), int'(e_seg));
    chk(reg_direct == (md == 2'b11), "R1 regdir", int'(reg_direct), int'(md == 2'b11));
    if (md == 2'b11) begin
      chk(reg_num == rm, "R1 num", int'(reg_num), int'(rm));
      chk(reg_wide == w, "R1 wide", int'(reg_wide), int'(w));
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(done == 1'b0, "R12 pulse", int'(done), 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R13 reset done", int'(done), 0);
    chk(in_ready == 1'b1, "R13 reset ready", int'(in_ready), 1);

    // R7: wrap past 0xFFFF
    reg_bx = 16'hFFFF; reg_si = 16'h0002;
    run_op(2'b01, 3'd0, 8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    // R4: sign-extension boundaries
    reg_bp = 16'h1000; reg_di = 16'h0000;
    run_op(2'b01, 3'd6, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    run_op(2'b01, 3'd6, 8'h7F, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    // R3: direct address, DS even though r/m is 110
    run_op(2'b00, 3'd6, 8'h34, 8'h12, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    // R9: valid override to CS, then R11: next op back to default SS
    run_op(2'b10, 3'd2, 8'h01, 8'h02, 1'b0, 1'b0, 1'b1, 8'h2E, 1'b1);
    run_op(2'b10, 3'd2, 8'h01, 8'h02, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    // R9: malformed override ignored
    run_op(2'b00, 3'd7, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h2F, 1'b1);
    // R10: string destination beats override
    run_op(2'b00, 3'd5, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 8'h3E, 1'b1);
    // R1: register-direct both widths
    run_op(2'b11, 3'd4, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1);
    run_op(2'b11, 3'd7, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);

    // R13: reset mid-operand with an override pending
    post_ovr(8'h26);
    send_byte(8'h80); // mode 10, rm 000
    send_byte(8'h55);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1'b1, "R13 ready after reset", int'(in_ready), 1);
    reg_bp = 16'h0200; reg_si = 16'h0030;
    run_op(2'b00, 3'd2, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ob;
      ob = ($urandom_range(0, 3) != 0) ? {3'b001, 2'($urandom), 3'b110} : 8'($urandom);
      run_op(2'($urandom), 3'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
             ($urandom_range(0, 5) == 0), 1'($urandom), ob, 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule